// File: doc/BRIEF.md
# Four-Channel Periodic Down-Counter Timer

This block holds four independent 32-bit down-counters behind a plain register bus, with one write strobe, an address, write data and a combinational read-data return. Software writes a reload value into a channel and sets the channel's enable bit. The counter then steps down once per counting event. When the counter is at zero, that event sets the channel's flag and refills the counter from its reload register, so the channel runs periodically with no further help from software. Each channel drives an interrupt line that is qualified by its own interrupt-enable bit. The flag is cleared by writing a one to it.

A channel other than the first can be switched from counting clock cycles to counting the wrap events of the channel just below it. Pairing the first two channels in this way gives a 64-bit timer. One global stop bit freezes every channel at once. A new reload value written during a running period does not touch the count in progress. Only turning the enable bit off and back on starts a fresh period.

Top module: `prd_timer`

## Requirements
- R1: After reset the global register at offset 0x000 reads 0x0000_0002, so the stop bit (bit 1) is set. Every channel register reads 0 and every interrupt output is low.
- R2: While global bit 1 is set, no channel's current value changes, except through an enable start (R4). Clearing bit 1 lets counting resume from the held value.
- R3: Channel n (n = 0..3) decodes at 0x100 + 0x10*n: reload at +0x0, current value at +0x4, control at +0x8, flag at +0xC. Any other offset reads 0.
- R4: A control write that takes bit 0 (enable) from 0 to 1 loads the current value from the reload register. While enabled, the current value drops by one per counting event. While disabled, it holds its value.
- R5: A counting event that finds the current value at 0 reloads it and sets flag bit 0. A period therefore lasts reload+1 events. Reload values of 0, 1 and 0xFFFF_FFFF all behave this way.
- R6: Writing the reload register of a running channel leaves the current count unchanged. The new value takes effect at the next wrap.
- R7: Writing a 1 to flag bit 0 clears the flag. Writing a 0 leaves it unchanged.
- R8: Interrupt output n is high exactly while channel n's flag and its control bit 1 (interrupt enable) are both set. Setting bit 1 while the flag is already set raises the output at once.
- R9: On channels 1..3, control bit 2 (chain) makes the channel count wrap events of channel n-1 instead of clock cycles. A chained channel still needs its own enable bit. Channel 0 ignores bit 2 and keeps counting clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Per-channel interrupt, active high |

## Verification
The hardest situation to reach is a chained channel whose value must stay still while the clock runs and then move exactly once per wrap of its neighbour. To get there, the bench first arms the upper channel while the lower one is idle and confirms that the upper value does not change. It then starts the lower channel with a short reload, waits a whole number of lower periods, and checks that the upper value dropped by that number. Finally it turns off the upper channel's enable while keeping its chain bit, and shows that wraps from below no longer move it. Reloading a running channel is reached by rewriting the reload register at mid-count and then crossing one wrap.

// File: rtl/prd_timer_pkg.sv
// Package: shared constants and types for the periodic down-counter timer.
// Assumes byte addressing with 32-bit word-aligned registers.
package prd_timer_pkg;

    localparam int GLB_OFS     = 0;      // global register offset
    localparam int CH_BASE     = 256;    // first channel window
    localparam int CH_STRIDE   = 16;     // bytes per channel window
    localparam int GLB_STOP    = 1;      // global stop bit position

    localparam logic [1:0] SEL_RELOAD = 2'd0;
    localparam logic [1:0] SEL_VALUE  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_FLAG   = 2'd3;

    // Channel control bits; packed MSB first so enable lands at bit 0.
    typedef struct packed {
        logic chain;
        logic ie;
        logic en;
    } chan_ctrl_t;

endpackage

// File: rtl/prd_timer_dec.sv
// Module: address decoder. Splits a byte address into a global-register hit
// or a channel hit with channel index and register select.
// Assumes channel windows are contiguous starting at CH_BASE.
module prd_timer_dec
    import prd_timer_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              glb_hit_o,
    output logic              ch_hit_o,
    output logic [IDX_W-1:0]  ch_idx_o,
    output logic [1:0]        sel_o
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_CH * CH_STRIDE);

    logic [ADDR_W-1:0] rel;

    // Offset of the address relative to the first channel window.
    always_comb begin
        rel       = addr_i - BASE_A;
        glb_hit_o = (addr_i == ADDR_W'(GLB_OFS));
        ch_hit_o  = (addr_i >= BASE_A) && (rel < SPAN_A) && (addr_i[1:0] == 2'b00);
        ch_idx_o  = rel[IDX_W+3:4];
        sel_o     = rel[3:2];
    end

endmodule

// File: rtl/prd_timer_chan.sv
// Module: one timer channel. Holds reload, current value, control and flag.
// Counts clock cycles, or wrap events of the channel below when chained.
// Assumes wdata is at least CNT_W bits wide and at least 3 bits.
module prd_timer_chan
    import prd_timer_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int DATA_W    = 32,
    parameter bit HAS_CHAIN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              prev_expire_i,
    input  logic              wr_reload_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_flag_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              expire_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  value_o,
    output chan_ctrl_t        ctrl_o,
    output logic              flag_o,
    output logic              irq_o
);

    chan_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] value_q;
    logic             flag_q;
    logic             chained;
    logic             tick;
    logic             start;

    // Counting event selection and start/wrap detection.
    always_comb begin
        chained  = HAS_CHAIN && ctrl_q.chain;
        tick     = run_i && ctrl_q.en && (chained ? prev_expire_i : 1'b1);
        expire_o = tick && (value_q == '0);
        start    = wr_ctrl_i && wdata_i[0] && !ctrl_q.en;
    end

    // Reload register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '0;
        else if (wr_reload_i) reload_q <= wdata_i[CNT_W-1:0];
    end

    // Control register: enable, interrupt enable, chain.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wr_ctrl_i) ctrl_q <= chan_ctrl_t'(wdata_i[2:0]);
    end

    // Current value: load on start, refill on wrap, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)        value_q <= '0;
        else if (start)    value_q <= reload_q;
        else if (expire_o) value_q <= reload_q;
        else if (tick)     value_q <= value_q - 1'b1;
    end

    // Flag: set on wrap (wins over clear), cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (expire_o)               flag_q <= 1'b1;
        else if (wr_flag_i && wdata_i[0]) flag_q <= 1'b0;
    end

    assign reload_o = reload_q;
    assign value_o  = value_q;
    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;
    assign irq_o    = flag_q && ctrl_q.ie;

endmodule

// File: rtl/prd_timer_rdmux.sv
// Module: read-data multiplexer. Returns the register picked by the decoder;
// unmapped addresses return zero. Purely combinational.
module prd_timer_rdmux
    import prd_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                           glb_hit_i,
    input  logic                           ch_hit_i,
    input  logic [IDX_W-1:0]               ch_idx_i,
    input  logic [1:0]                     sel_i,
    input  logic                           stop_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   reload_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   value_i,
    input  logic [NUM_CH-1:0][2:0]         ctrl_i,
    input  logic [NUM_CH-1:0]              flag_i,
    output logic [DATA_W-1:0]              rdata_o
);

    // Select one register by decoded address.
    always_comb begin
        rdata_o = '0;
        if (glb_hit_i) begin
            rdata_o[GLB_STOP] = stop_i;
        end else if (ch_hit_i) begin
            unique case (sel_i)
                SEL_RELOAD: rdata_o = DATA_W'(reload_i[ch_idx_i]);
                SEL_VALUE:  rdata_o = DATA_W'(value_i[ch_idx_i]);
                SEL_CTRL:   rdata_o = DATA_W'(ctrl_i[ch_idx_i]);
                default:    rdata_o = DATA_W'(flag_i[ch_idx_i]);
            endcase
        end
    end

endmodule

// File: rtl/prd_timer.sv
// Module: top of the periodic down-counter timer. Decodes bus writes,
// holds the global stop bit, instantiates the channels in a chain and
// drives read data. Assumes single-cycle writes and combinational reads.
module prd_timer
    import prd_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                         glb_hit;
    logic                         ch_hit;
    logic [IDX_W-1:0]             ch_idx;
    logic [1:0]                   sel;
    logic                         stop_q;
    logic                         run;
    logic [NUM_CH-1:0]            wr_reload_v;
    logic [NUM_CH-1:0]            wr_ctrl_v;
    logic [NUM_CH-1:0]            wr_flag_v;
    logic [NUM_CH-1:0]            ch_expire;
    logic [NUM_CH-1:0]            ch_flag;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_reload;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_value;
    logic [NUM_CH-1:0][2:0]       ch_ctrl;
    logic [NUM_CH:0]              chain_link;

    prd_timer_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr_i    (bus_addr),
        .glb_hit_o (glb_hit),
        .ch_hit_o  (ch_hit),
        .ch_idx_o  (ch_idx),
        .sel_o     (sel)
    );

    // Global stop bit: set out of reset, written through the global register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stop_q <= 1'b1;
        else if (bus_wr && glb_hit) stop_q <= bus_wdata[GLB_STOP];
    end

    assign run           = !stop_q;
    assign chain_link[0] = 1'b0;

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_ch
            chan_ctrl_t ctrl_s;
            logic       ch_sel;

            // Per-channel write strobes from the shared decode.
            always_comb begin
                ch_sel         = bus_wr && ch_hit && (ch_idx == IDX_W'(n));
                wr_reload_v[n] = ch_sel && (sel == SEL_RELOAD);
                wr_ctrl_v[n]   = ch_sel && (sel == SEL_CTRL);
                wr_flag_v[n]   = ch_sel && (sel == SEL_FLAG);
            end

            prd_timer_chan #(
                .CNT_W     (CNT_W),
                .DATA_W    (DATA_W),
                .HAS_CHAIN (n != 0)
            ) u_chan (
                .clk           (clk),
                .rst_n         (rst_n),
                .run_i         (run),
                .prev_expire_i (chain_link[n]),
                .wr_reload_i   (wr_reload_v[n]),
                .wr_ctrl_i     (wr_ctrl_v[n]),
                .wr_flag_i     (wr_flag_v[n]),
                .wdata_i       (bus_wdata),
                .expire_o      (ch_expire[n]),
                .reload_o      (ch_reload[n]),
                .value_o       (ch_value[n]),
                .ctrl_o        (ctrl_s),
                .flag_o        (ch_flag[n]),
                .irq_o         (irq[n])
            );

            assign ch_ctrl[n]      = ctrl_s;
            assign chain_link[n+1] = ch_expire[n];
        end
    endgenerate

    prd_timer_rdmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rdmux (
        .glb_hit_i (glb_hit),
        .ch_hit_i  (ch_hit),
        .ch_idx_i  (ch_idx),
        .sel_i     (sel),
        .stop_i    (stop_q),
        .reload_i  (ch_reload),
        .value_i   (ch_value),
        .ctrl_i    (ch_ctrl),
        .flag_i    (ch_flag),
        .rdata_o   (bus_rdata)
    );

endmodule

// File: rtl/prd_timer_chk.sv
// Module: property checker bound to prd_timer. Observes channel state and
// write strobes; drives nothing.
module prd_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         run,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [NUM_CH-1:0]            wr_ctrl_v,
    input logic [NUM_CH-1:0]            wr_flag_v,
    input logic [NUM_CH-1:0]            ch_expire,
    input logic [NUM_CH-1:0]            ch_flag,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_reload,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_value,
    input logic [NUM_CH-1:0][2:0]       ch_ctrl,
    input logic [NUM_CH-1:0]            irq
);

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_chk
            AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !wr_ctrl_v[n]) |=> $stable(ch_value[n])); // R2

            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_ctrl[n][0] && !wr_ctrl_v[n]) |=> $stable(ch_value[n])); // R4

            AST_WRAP_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
                ch_expire[n] |=> (ch_flag[n] && ch_value[n] == $past(ch_reload[n]))); // R5

            AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_flag_v[n] && !bus_wdata[0] && !ch_expire[n]) |=> $stable(ch_flag[n])); // R7

            AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                irq[n] |-> ch_flag[n]); // R8

            if (n > 0) begin : g_link
                AST_CHAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                    (ch_ctrl[n][2] && !ch_expire[n-1] && !wr_ctrl_v[n])
                    |=> $stable(ch_value[n])); // R9
            end
        end
    endgenerate

endmodule

bind prd_timer prd_timer_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .bus_wdata (bus_wdata),
    .wr_ctrl_v (wr_ctrl_v),
    .wr_flag_v (wr_flag_v),
    .ch_expire (ch_expire),
    .ch_flag   (ch_flag),
    .ch_reload (ch_reload),
    .ch_value  (ch_value),
    .ch_ctrl   (ch_ctrl),
    .irq       (irq)
);

// File: tb/test_prd_timer.sv
`timescale 1ns/1ps
module test_prd_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prd_timer i_prd_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] reload;
        logic [31:0] wait_n;
        logic [31:0] exp_val;
        logic        exp_flag;
    } vec_t;

    // Period checks: value and flag after wait_n clocks from an enable start.
    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'd10,         32'd3,   32'd7,          1'b0},
        '{2'd0, 32'd10,         32'd10,  32'd0,          1'b0},
        '{2'd0, 32'd10,         32'd11,  32'd10,         1'b1},
        '{2'd1, 32'd1,          32'd1,   32'd0,          1'b0},
        '{2'd1, 32'd1,          32'd2,   32'd1,          1'b1},
        '{2'd2, 32'd1,          32'd5,   32'd0,          1'b1},
        '{2'd3, 32'hFFFF_FFFF,  32'd5,   32'hFFFF_FFFA,  1'b0},
        '{2'd2, 32'd0,          32'd3,   32'd0,          1'b1},
        '{2'd3, 32'd100,        32'd250, 32'd52,         1'b1}
    };

    function automatic logic [11:0] ra(input int ch, input int off);
        return 12'(256 + 16 * ch + off);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(12'h000, d);    check("R1 global reg", d, 32'h2);
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 16; o += 4) begin
                rd(ra(c, o), d); check("R1 channel reg", d, 32'h0);
            end
        end
        check("R1 irq", {28'h0, irq}, 32'h0);
        // R3: unmapped offsets
        rd(12'h004, d);    check("R3 unmapped 0x004", d, 32'h0);
        rd(12'h140, d);    check("R3 unmapped 0x140", d, 32'h0);
        rd(12'h102, d);    check("R3 unaligned", d, 32'h0);

        // R2: stopped module holds value, resumes when bit cleared
        wr(ra(0, 0), 32'd5);
        wr(ra(0, 8), 32'h1);
        wait_clk(10);
        rd(ra(0, 4), d);   check("R2 held while stopped", d, 32'd5);
        wr(12'h000, 32'h0);
        rd(12'h000, d);    check("R2 global cleared", d, 32'h0);
        wait_clk(2);
        rd(ra(0, 4), d);   check("R2 resumed", d, 32'd3);
        wr(ra(0, 8), 32'h0);

        // R4 R5: period table
        for (int v = 0; v < NVEC; v++) begin
            wr(ra(VECS[v].ch, 8), 32'h0);
            wr(ra(VECS[v].ch, 0), VECS[v].reload);
            wr(ra(VECS[v].ch, 12), 32'h1);
            wr(ra(VECS[v].ch, 8), 32'h1);
            wait_clk(int'(VECS[v].wait_n));
            rd(ra(VECS[v].ch, 4), d);  check("R4 R5 value", d, VECS[v].exp_val);
            rd(ra(VECS[v].ch, 12), d); check("R5 flag", d, {31'h0, VECS[v].exp_flag});
        end
        for (int c = 0; c < 4; c++) begin
            wr(ra(c, 8), 32'h0);
            wr(ra(c, 12), 32'h1);
        end

        // R2: stop mid-run
        wr(ra(2, 0), 32'd50);
        wr(ra(2, 8), 32'h1);
        wait_clk(2);
        wr(12'h000, 32'h2);
        wait_clk(10);
        rd(ra(2, 4), d);   check("R2 frozen mid-run", d, 32'd47);
        wr(12'h000, 32'h0);
        wait_clk(3);
        rd(ra(2, 4), d);   check("R2 after restart", d, 32'd44);

        // R4: disable then enable restarts from reload
        wr(ra(2, 8), 32'h0);
        wr(ra(2, 0), 32'd20);
        wr(ra(2, 8), 32'h1);
        wait_clk(5);
        wr(ra(2, 8), 32'h0);
        rd(ra(2, 4), d);   check("R4 disabled value", d, 32'd14);
        wait_clk(4);
        rd(ra(2, 4), d);   check("R4 disabled holds", d, 32'd14);
        wr(ra(2, 8), 32'h1);
        rd(ra(2, 4), d);   check("R4 restart loads", d, 32'd20);
        wr(ra(2, 8), 32'h0);

        // R6: reload write while running
        wr(ra(1, 0), 32'd20);
        wr(ra(1, 12), 32'h1);
        wr(ra(1, 8), 32'h1);
        wait_clk(5);
        wr(ra(1, 0), 32'd5);
        rd(ra(1, 4), d);   check("R6 count undisturbed", d, 32'd14);
        rd(ra(1, 12), d);  check("R6 no flag yet", d, 32'h0);
        wait_clk(15);
        rd(ra(1, 4), d);   check("R6 new reload at wrap", d, 32'd5);
        rd(ra(1, 12), d);  check("R6 flag at wrap", d, 32'h1);
        wr(ra(1, 8), 32'h0);
        wr(ra(1, 12), 32'h1);

        // R7 R8: flag clearing and interrupt gating
        wr(ra(3, 0), 32'd2);
        wr(ra(3, 12), 32'h1);
        wr(ra(3, 8), 32'h1);
        wait_clk(3);
        rd(ra(3, 12), d);  check("R7 flag set", d, 32'h1);
        check("R8 irq gated off", {28'h0, irq}, 32'h0);
        wr(ra(3, 8), 32'h0);
        wr(ra(3, 12), 32'h0);
        rd(ra(3, 12), d);  check("R7 write zero ignored", d, 32'h1);
        wr(ra(3, 8), 32'h2);
        check("R8 irq on enable", {28'h0, irq}, 32'h8);
        wr(ra(3, 12), 32'h1);
        rd(ra(3, 12), d);  check("R7 write one clears", d, 32'h0);
        check("R8 irq drops", {28'h0, irq}, 32'h0);
        wr(ra(3, 8), 32'h0);

        // R9: channel 0 ignores chain bit
        wr(ra(0, 0), 32'd9);
        wr(ra(0, 8), 32'h5);
        wait_clk(4);
        rd(ra(0, 4), d);   check("R9 ch0 chain ignored", d, 32'd5);
        wr(ra(0, 8), 32'h0);

        // R9: channel 1 counts wraps of channel 0
        wr(ra(0, 0), 32'd3);
        wr(ra(1, 0), 32'd100);
        wr(ra(1, 8), 32'h5);
        wait_clk(3);
        rd(ra(1, 4), d);   check("R9 chained idle", d, 32'd100);
        wr(ra(0, 8), 32'h1);
        wait_clk(8);
        rd(ra(1, 4), d);   check("R9 counts wraps", d, 32'd98);
        wr(ra(1, 8), 32'h4);
        wait_clk(8);
        rd(ra(1, 4), d);   check("R9 needs own enable", d, 32'd98);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule